// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block is one channel of a DMA engine. It copies a run of 32-bit words between a word-addressed main memory and a peripheral data port, in either direction. Software sets it up through three registers: a start address, a block-size word and a control word. Writing the control word with its run bit set starts a transfer. The full 32-bit control value chooses the direction. Any value the block does not recognise ends the transfer at once and moves no data.

The length is the number of blocks times the number of words per block. Each cycle in which the memory and the peripheral are both ready moves one word. On completion the run bit clears, the address register moves past the transfer and a one-cycle interrupt pulse is raised. Accesses that would run past the end of memory are cut short, but the address register still advances by the full length. A start address outside memory gives a transfer that moves nothing and leaves the address register unchanged.

Top module: `dma_block_channel`

## Requirements
- R1: After reset all three registers read zero, `irq` is low, and `mem_req`, `per_wvalid` and `per_rready` are low.
- R2: `reg_wr_sel`/`reg_rd_sel` value 0 selects the address register, 1 the block register and 2 the control register. Value 3 reads zero. The address register always reads with bits [1:0] zero, whatever was written there.
- R3: A control write with bit 24 set while bit 24 is clear starts a transfer. Value 0x01000201 moves memory to peripheral, and value 0x01000200 moves peripheral to memory. A control write with bit 24 clear is only stored and starts nothing.
- R4: The transfer length is block[31:16] times block[15:0]. Memory is accessed at consecutive word addresses starting at address[31:2].
- R5: A word moves in each cycle in which `mem_ready` and the peripheral side (`per_wready` or `per_rvalid`) are both high. Otherwise the transfer waits. With no stalls, a transfer of N words shows `irq` N+1 cycles after the cycle in which the control write was clocked in.
- R6: On completion, control bit 24 clears, the address register becomes the aligned start address plus 4 times the length (modulo 2^32), and `irq` is high for exactly one cycle.
- R7: A control write with bit 24 set and any other value moves no data. The address register is kept, bit 24 clears, and `irq` is high in the cycle after the one following the write.
- R8: Words whose address would be at or above MEM_WORDS are not moved. The address register still advances by the full length.
- R9: If the start word address is at or above MEM_WORDS, no data moves, the address register is kept, and the channel completes as in R7.
- R10: While bit 24 is set, a control write has no effect on the control register or on the running transfer.
- R11: A length of zero with a recognised mode moves nothing. The channel completes as in R7, and the address register becomes the aligned start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register written (0 address, 1 block, 2 control) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Register read back |
| reg_rd_data | output | 32 | Read-back data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| per_wvalid | output | 1 | Word offered to the peripheral |
| per_wready | input | 1 | Peripheral takes a word |
| per_wdata | output | 32 | Word to the peripheral |
| per_rvalid | input | 1 | Peripheral offers a word |
| per_rready | output | 1 | Channel takes the peripheral word |
| per_rdata | input | 32 | Word from the peripheral |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions check these rules on every cycle:
- The run bit matches whether the engine is active.
- Every handshake removes exactly one word from the remaining count.
- The interrupt only ever follows a finishing cycle.
- A busy control write leaves the control register unchanged.
- An unrecognised start goes straight to finishing.

Only the bench scenarios can show the following:
- The data moved and its order.
- The cut at the memory edge.
- The written-back address values.
- The completion latency with and without stalls.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned RUN_BIT = 24;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_BLOCK = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  // Control values that select a direction; anything else is unrecognised
  localparam logic [31:0] CTRL_MEM_TO_PER = 32'h0100_0201;
  localparam logic [31:0] CTRL_PER_TO_MEM = 32'h0100_0200;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FINISH
  } ch_state_e;

  typedef struct packed {
    logic        run;       // at least one word will move
    logic        to_per;    // memory -> peripheral
    logic        upd_addr;  // write the address register back at the end
    logic [31:0] words;     // words actually moved (after truncation)
    logic [31:0] end_addr;  // address register value after completion
  } launch_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  input  logic        finish,
  input  logic        upd_addr,
  input  logic [31:0] end_addr,
  output logic [31:0] addr_q,
  output logic [31:0] block_q,
  output logic [31:0] ctrl_q,
  output logic [31:0] rd_data,
  output logic        start
);
  logic        addr_en, block_en, ctrl_en;
  logic [31:0] addr_d, ctrl_d;
  logic        ctrl_wr;

  always_comb begin
    ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    start    = ctrl_wr && wr_data[RUN_BIT] && !ctrl_q[RUN_BIT];
    addr_en  = (wr_en && (wr_sel == SEL_ADDR)) || (finish && upd_addr);
    addr_d   = (finish && upd_addr) ? end_addr : {wr_data[31:2], 2'b00};
    block_en = wr_en && (wr_sel == SEL_BLOCK);
    ctrl_en  = (ctrl_wr && !ctrl_q[RUN_BIT]) || finish;
    ctrl_d   = wr_data;
    if (finish) begin
      ctrl_d          = ctrl_q;
      ctrl_d[RUN_BIT] = 1'b0;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_ADDR:  rd_data = addr_q;
      SEL_BLOCK: rd_data = block_q;
      SEL_CTRL:  rd_data = ctrl_q;
      default:   rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      block_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (addr_en)  addr_q  <= addr_d;
      if (block_en) block_q <= wr_data;
      if (ctrl_en)  ctrl_q  <= ctrl_d;
    end
  end

  // R10: a control write during a transfer leaves the control register alone
  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_q[RUN_BIT] && !finish) |=> $stable(ctrl_q));
endmodule

// File: rtl/dma_chan_launch.sv
module dma_chan_launch
  import dma_chan_pkg::*;
#(
  parameter  int unsigned MEM_WORDS = 524288,
  localparam int unsigned MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic [31:0]       addr_q,
  input  logic [31:0]       block_q,
  input  logic [31:0]       ctrl_val,
  output launch_t           launch,
  output logic [MEM_AW-1:0] start_word
);
  localparam logic [31:0] MEM_LIMIT = 32'(MEM_WORDS);

  logic [31:0] total, word_idx, room;
  logic        known, start_ok;

  always_comb begin
    total    = 32'(block_q[31:16]) * 32'(block_q[15:0]);
    word_idx = {2'b00, addr_q[31:2]};
    start_ok = word_idx < MEM_LIMIT;
    room     = MEM_LIMIT - word_idx;
    known    = (ctrl_val == CTRL_MEM_TO_PER) || (ctrl_val == CTRL_PER_TO_MEM);

    launch.to_per   = (ctrl_val == CTRL_MEM_TO_PER);
    launch.upd_addr = known && start_ok;
    launch.words    = (total < room) ? total : room;
    launch.run      = known && start_ok && (launch.words != 32'd0);
    launch.end_addr = addr_q + (total << 2);
    start_word      = addr_q[MEM_AW+1:2];
  end
endmodule

// File: rtl/dma_chan_mover.sv
module dma_chan_mover
  import dma_chan_pkg::*;
#(
  parameter  int unsigned MEM_WORDS = 524288,
  localparam int unsigned MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  launch_t           launch,
  input  logic [MEM_AW-1:0] start_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              per_wvalid,
  input  logic              per_wready,
  output logic [31:0]       per_wdata,
  input  logic              per_rvalid,
  output logic              per_rready,
  input  logic [31:0]       per_rdata,
  output logic              finish,
  output logic              busy,
  output logic              upd_addr,
  output logic [31:0]       end_addr
);
  ch_state_e         state_q, state_d;
  logic              to_per_q, to_per_d;
  logic [MEM_AW-1:0] waddr_q, waddr_d;
  logic [31:0]       remain_q, remain_d;
  logic              upd_q, upd_d;
  logic [31:0]       end_q, end_d;
  logic              running, per_ok, fire, load;

  always_comb begin
    running    = (state_q == ST_RUN);
    per_ok     = to_per_q ? per_wready : per_rvalid;
    fire       = running && per_ok && mem_ready;
    mem_req    = running && per_ok;
    mem_we     = running && !to_per_q;
    mem_addr   = waddr_q;
    mem_wdata  = per_rdata;
    per_wvalid = running && to_per_q && mem_ready;
    per_wdata  = mem_rdata;
    per_rready = running && !to_per_q && mem_ready;
    finish     = (state_q == ST_FINISH);
    busy       = (state_q != ST_IDLE);
    upd_addr   = upd_q;
    end_addr   = end_q;
  end

  always_comb begin
    state_d  = state_q;
    to_per_d = to_per_q;
    waddr_d  = waddr_q;
    remain_d = remain_q;
    upd_d    = upd_q;
    end_d    = end_q;
    load     = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        load     = 1'b1;
        to_per_d = launch.to_per;
        waddr_d  = start_word;
        remain_d = launch.words;
        upd_d    = launch.upd_addr;
        end_d    = launch.end_addr;
        state_d  = launch.run ? ST_RUN : ST_FINISH;
      end
      ST_RUN: if (fire) begin
        waddr_d  = waddr_q + 1'b1;
        remain_d = remain_q - 32'd1;
        if (remain_q == 32'd1) state_d = ST_FINISH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      to_per_q <= 1'b0;
      waddr_q  <= '0;
      remain_q <= '0;
      upd_q    <= 1'b0;
      end_q    <= '0;
    end else begin
      state_q <= state_d;
      if (load || fire) begin
        waddr_q  <= waddr_d;
        remain_q <= remain_d;
      end
      if (load) begin
        to_per_q <= to_per_d;
        upd_q    <= upd_d;
        end_q    <= end_d;
      end
    end
  end

  // R5: each accepted word takes exactly one off the remaining count
  assert_one_word_per_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (remain_q == $past(remain_q) - 32'd1));
  // R5: the sides only see traffic while running
  assert_quiet_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> !(mem_req || per_wvalid || per_rready));
  // R6: the finishing state lasts one cycle
  assert_finish_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FINISH) |=> (state_q == ST_IDLE));
  // R7: a start that moves nothing goes straight to finishing
  assert_empty_start_finishes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (state_q == ST_IDLE) && !launch.run) |=> (state_q == ST_FINISH));
endmodule

// File: rtl/dma_block_channel.sv
module dma_block_channel
  import dma_chan_pkg::*;
#(
  parameter  int unsigned MEM_WORDS = 524288,
  localparam int unsigned MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  input  logic [1:0]        reg_rd_sel,
  output logic [31:0]       reg_rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              per_wvalid,
  input  logic              per_wready,
  output logic [31:0]       per_wdata,
  input  logic              per_rvalid,
  output logic              per_rready,
  input  logic [31:0]       per_rdata,
  output logic              irq
);
  logic [31:0]       addr_q, block_q, ctrl_q, end_addr;
  logic              start, finish, busy, upd_addr;
  launch_t           launch;
  logic [MEM_AW-1:0] start_word;
  logic              irq_q;

  dma_chan_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .rd_sel(reg_rd_sel), .finish(finish), .upd_addr(upd_addr),
    .end_addr(end_addr), .addr_q(addr_q), .block_q(block_q),
    .ctrl_q(ctrl_q), .rd_data(reg_rd_data), .start(start)
  );

  dma_chan_launch #(.MEM_WORDS(MEM_WORDS)) u_launch (
    .addr_q(addr_q), .block_q(block_q), .ctrl_val(reg_wr_data),
    .launch(launch), .start_word(start_word)
  );

  dma_chan_mover #(.MEM_WORDS(MEM_WORDS)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .launch(launch),
    .start_word(start_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .per_wvalid(per_wvalid), .per_wready(per_wready), .per_wdata(per_wdata),
    .per_rvalid(per_rvalid), .per_rready(per_rready), .per_rdata(per_rdata),
    .finish(finish), .busy(busy), .upd_addr(upd_addr), .end_addr(end_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= finish;
  end
  assign irq = irq_q;

  // R3: the software-visible run bit tracks the engine
  assert_run_bit_tracks_engine_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[RUN_BIT] == busy);
  // R6: an interrupt only follows a finishing cycle
  assert_irq_after_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(finish));
endmodule

// File: tb/dma_block_channel_tb.sv
module dma_block_channel_tb;
  localparam int MW = 64;
  localparam logic [31:0] TO_PER = 32'h0100_0201;
  localparam logic [31:0] TO_MEM = 32'h0100_0200;

  typedef struct packed {
    logic [31:0] madr;
    logic [31:0] bcr;
    logic [31:0] ctrl;
    logic [31:0] words;
    logic [31:0] end_addr;
    logic        imm;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h10,  32'h0002_0003, TO_PER,        32'd6,  32'h28,  1'b0, 1'b1},
    '{32'h43,  32'h0001_0005, TO_MEM,        32'd5,  32'h54,  1'b0, 1'b1},
    '{32'hF0,  32'h0004_0002, TO_PER,        32'd4,  32'h110, 1'b0, 1'b0},
    '{32'h100, 32'h0001_0004, TO_MEM,        32'd0,  32'h100, 1'b1, 1'b0},
    '{32'h20,  32'h0001_0002, 32'h0100_0401, 32'd0,  32'h20,  1'b1, 1'b0},
    '{32'h30,  32'h0000_0007, TO_PER,        32'd0,  32'h30,  1'b1, 1'b0},
    '{32'hF8,  32'h0001_0003, TO_MEM,        32'd2,  32'h104, 1'b0, 1'b1},
    '{32'h00,  32'h0003_0004, TO_MEM,        32'd12, 32'h30,  1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_sel = 2'd0;
  logic [31:0] reg_rd_data;
  logic        mem_req, mem_we, mem_ready;
  logic [5:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        per_wvalid, per_wready, per_rvalid, per_rready;
  logic [31:0] per_wdata, per_rdata;
  logic        irq;

  always #10 clk = ~clk;

  dma_block_channel #(.MEM_WORDS(MW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .per_wvalid(per_wvalid), .per_wready(per_wready), .per_wdata(per_wdata),
    .per_rvalid(per_rvalid), .per_rready(per_rready), .per_rdata(per_rdata),
    .irq(irq)
  );

  // Memory and peripheral models
  logic [7:0]  cyc = '0;
  logic        stall = 1'b0, hold_per = 1'b0, fill_req = 1'b0;
  logic [31:0] mem [MW];
  logic [31:0] sink_buf [MW];
  int          mem_wr_cnt = 0, sink_cnt = 0, src_cnt = 0, irq_cnt = 0;

  assign mem_ready  = !stall || (cyc[1:0] != 2'd3);
  assign per_wready = !hold_per && (!stall || (cyc[2:0] != 3'd5));
  assign per_rvalid = !hold_per && (!stall || (cyc[1:0] != 2'd1));
  assign mem_rdata  = mem[mem_addr];
  assign per_rdata  = 32'hC0DE_0000 + 32'(src_cnt);

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (fill_req) begin
      for (int i = 0; i < MW; i++) mem[i] <= 32'hA500_0000 + 32'(i);
    end else if (mem_req && mem_ready && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      mem_wr_cnt    <= mem_wr_cnt + 1;
    end
    if (per_wvalid && per_wready) begin
      sink_buf[sink_cnt % MW] <= per_wdata;
      sink_cnt                <= sink_cnt + 1;
    end
    if (per_rvalid && per_rready) src_cnt <= src_cnt + 1;
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = s; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    reg_rd_sel = s;
    #1;
    d = reg_rd_data;
  endtask

  task automatic fill();
    @(negedge clk); fill_req = 1'b1;
    @(negedge clk); fill_req = 1'b0;
  endtask

  task automatic wait_irq(output int lat);
    lat = 0;
    while (!irq && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  vec_t cur;

  task automatic run_vector(input int v);
    int lat, sb, srcb, wb, ib, sw;
    logic [31:0] r;
    cur = VECS[v];
    stall = cur.stall;
    fill();
    sb = sink_cnt; srcb = src_cnt; wb = mem_wr_cnt; ib = irq_cnt;
    sw = int'(cur.madr[31:2]);
    wr(2'd0, cur.madr);
    wr(2'd1, cur.bcr);
    wr(2'd2, cur.ctrl);
    wait_irq(lat);
    check("R6 irq seen", 32'(irq), 32'd1);
    if (cur.imm) check("R7/R9/R11 immediate latency", 32'(lat), 32'd1);
    check("R4/R8 words moved", 32'((sink_cnt - sb) + (mem_wr_cnt - wb)), cur.words);
    rd(2'd0, r);
    check("R6/R8/R9 address writeback", r, cur.end_addr);
    rd(2'd2, r);
    check("R6/R7 run bit cleared", r, cur.ctrl & ~32'h0100_0000);
    if (cur.ctrl == TO_PER) begin
      for (int i = 0; i < int'(cur.words); i++)
        check("R4/R5 peripheral data", sink_buf[(sb + i) % MW], 32'hA500_0000 + 32'(sw + i));
    end
    if (cur.ctrl == TO_MEM) begin
      for (int i = 0; i < int'(cur.words); i++)
        check("R4/R5 memory data", mem[sw + i], 32'hC0DE_0000 + 32'(srcb + i));
      if (cur.words != 0 && sw + int'(cur.words) < MW)
        check("R4 word past end untouched", mem[sw + int'(cur.words)],
              32'hA500_0000 + 32'(sw + int'(cur.words)));
    end
    @(negedge clk);
    check("R6 irq single cycle", 32'(irq), 32'd0);
    check("R6 one irq per run", 32'(irq_cnt - ib), 32'd1);
  endtask

  initial begin
    logic [31:0] r;
    int lat, sb, ib;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    check("R1 per_wvalid", 32'(per_wvalid), 32'd0);
    check("R1 per_rready", 32'(per_rready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), r);
      check("R1/R2 register reset", r, 32'd0);
    end

    // R2: register access and address alignment
    wr(2'd0, 32'h0000_0047);
    rd(2'd0, r); check("R2 address low bits", r, 32'h0000_0044);
    wr(2'd1, 32'h1234_5678);
    rd(2'd1, r); check("R2 block readback", r, 32'h1234_5678);
    rd(2'd3, r); check("R2 unused select", r, 32'd0);

    // R3: control write without run bit only stores
    ib = irq_cnt;
    wr(2'd2, 32'h0000_0201);
    rd(2'd2, r); check("R3 stored control", r, 32'h0000_0201);
    repeat (4) @(negedge clk);
    check("R3 no start irq", 32'(irq_cnt - ib), 32'd0);
    check("R3 no start request", 32'(mem_req), 32'd0);

    // Table of transfers
    for (int v = 0; v < 8; v++) run_vector(v);

    // R5: unstalled throughput, 8 words -> irq after 9 cycles
    stall = 1'b0;
    fill();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0002_0004);
    wr(2'd2, TO_PER);
    wait_irq(lat);
    check("R5 unstalled latency", 32'(lat), 32'd9);

    // R10: control write while busy is ignored
    fill();
    hold_per = 1'b1;
    sb = sink_cnt;
    wr(2'd0, 32'h8);
    wr(2'd1, 32'h0001_0004);
    wr(2'd2, TO_PER);
    repeat (3) @(negedge clk);
    wr(2'd2, TO_MEM);
    rd(2'd2, r); check("R10 control kept while busy", r, TO_PER);
    check("R10 no writes to memory", 32'(mem_req && mem_we), 32'd0);
    hold_per = 1'b0;
    wait_irq(lat);
    check("R10 transfer completed", 32'(sink_cnt - sb), 32'd4);
    check("R10 direction unchanged", sink_buf[(sb + 3) % MW], 32'hA500_0005);
    rd(2'd2, r); check("R10 final control", r, 32'h0000_0201);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 200000, 0);
      summary();
    end
  end
endmodule